// File: doc/BRIEF.md
# Periodic PC and Data Address Sampler

This block takes periodic, non-intrusive snapshots of the program flow for profiling. A free-running interval timer expires once every 2^(5+rate) clock cycles. Each expiry arms a capture slot, and the slot latches the next qualifying event. An event is a retiring instruction for the PC slot and a load/store for the data address slot. The timer keeps running from expiry to expiry and never waits for a capture, so the sampling cadence does not depend on how often events occur.

Three control bits shape the captured data. One filter keeps only instructions that missed in the instruction cache. A second drops the address space identifier, which then reads as zero. A third keeps only data addresses that hit data breakpoint 0. The data address slot has its own enable and shares the PC timer, so the two slots can run together or alone.

Each slot presents its latched value and a new-data flag. A debugger reads the value and pulses the slot's read strobe to clear the flag. A later capture overwrites a value that was never read.

Top module: `pc_sampler`

## Requirements
- R1: With sampling enabled, the interval timer expires every 2^(5+cfg_rate) cycles (32 to 4096). Each expiry arms the slot, and the slot captures the first qualifying event in a later cycle.
- R2: With cfg_pc_en low, the PC slot captures nothing, and its flag and value stay unchanged. Clearing both enables returns the timer to zero.
- R3: With cfg_miss_only set, only retiring instructions with ret_miss=1 are captured.
- R4: With cfg_drop_asid set, a captured PC sample holds an ASID field of zero. With the bit clear, it holds ret_asid.
- R5: The data slot, enabled by cfg_da_en, captures ls_addr on the shared timer, independently of the PC slot.
- R6: With cfg_da_qual set, only load/store addresses with ls_bp0_hit=1 are captured.
- R7: An armed slot stays armed through cycles without a qualifying event and captures the first event that follows, however late it comes.
- R8: A read strobe clears the slot's new-data flag, unless a capture happens in the same cycle.
- R9: A capture sets the new-data flag and replaces the stored value, even when the previous value was never read.
- R10: After reset, both flags and all sample fields are zero.
- R11: At cfg_rate=7, consecutive samples under continuous retirement are 4096 cycles apart.
- R12: Dropping cfg_pc_en discards a pending arm, so no stale capture follows re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pc_en | input | 1 | Enable PC sampling |
| cfg_rate | input | 3 | Interval exponent: period 2^(5+rate) |
| cfg_miss_only | input | 1 | Capture only icache-missing instructions |
| cfg_drop_asid | input | 1 | Store zero in place of ASID |
| cfg_da_en | input | 1 | Enable data address sampling |
| cfg_da_qual | input | 1 | Capture only breakpoint-0 hits |
| ret_vld | input | 1 | Instruction retire strobe |
| ret_pc | input | 32 | PC of the retiring instruction |
| ret_asid | input | 8 | ASID of the retiring instruction |
| ret_miss | input | 1 | Retiring instruction missed in icache |
| ls_vld | input | 1 | Load/store strobe |
| ls_addr | input | 32 | Load/store data address |
| ls_bp0_hit | input | 1 | Data breakpoint 0 matched this access |
| pc_rd | input | 1 | Read strobe, clears PC new flag |
| da_rd | input | 1 | Read strobe, clears data new flag |
| pc_smp_pc | output | 32 | Sampled PC |
| pc_smp_asid | output | 8 | Sampled ASID (zero when dropped) |
| pc_smp_new | output | 1 | PC sample not yet read |
| da_smp_addr | output | 32 | Sampled data address |
| da_smp_new | output | 1 | Data sample not yet read |

## Verification
The bench drives a PC that encodes the cycle number, so every captured value shows the exact cycle of its capture. A timer that is off by one, or that restarts at capture rather than at expiry, therefore shows up as a wrong PC. Sparse retirement tests the arm-and-wait behaviour: a slot that drops its arm would lose samples. A slot that kept a stale arm across a disable would produce an extra one. The filters run against patterns in which a leaky filter would capture a non-missing PC, a non-zero ASID or an address with no breakpoint hit. Unread overwrite and read clearing are checked with the automatic reads turned off, and a slot that kept the older value or failed to clear its flag is reported.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int PCS_BASE_SHIFT = 5;

  // Counter width needed to reach the longest interval.
  function automatic int pcs_cnt_width(input int base_shift, input int rate_w);
    return base_shift + (1 << rate_w) - 1;
  endfunction

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'b00,
    SLOT_ARMED = 2'b01
  } slot_state_e;

endpackage

// File: rtl/pcs_interval_timer.sv
module pcs_interval_timer
  import pcs_pkg::*;
#(
  parameter int RATE_W     = 3,
  parameter int BASE_SHIFT = PCS_BASE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int MAX_RATE = (1 << RATE_W) - 1;
  localparam int CNT_W    = pcs_cnt_width(BASE_SHIFT, RATE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last_val;
  logic [RATE_W-1:0] shamt;

  // Terminal count is an all-ones pattern of length BASE_SHIFT+rate.
  always_comb begin
    shamt    = RATE_W'(MAX_RATE) - rate;
    last_val = {CNT_W{1'b1}} >> shamt;
    tick     = run && (cnt_q >= last_val);
  end

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_IDLE_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !tick); // R2

endmodule

// File: rtl/pcs_capture_slot.sv
module pcs_capture_slot
  import pcs_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         evt,
  input  logic         rd,
  input  logic [W-1:0] din,
  output logic [W-1:0] sample,
  output logic         fresh,
  output logic         cap
);

  slot_state_e  st_q, st_d;
  logic [W-1:0] smp_q, smp_d;
  logic         new_q, new_d;

  always_comb begin
    cap = (st_q == SLOT_ARMED) && en && evt;
    if (!en)      st_d = SLOT_IDLE;
    else if (tick) st_d = SLOT_ARMED;
    else if (cap)  st_d = SLOT_IDLE;
    else           st_d = st_q;
  end

  always_comb begin
    smp_d = cap ? din : smp_q;
    if (cap)     new_d = 1'b1;
    else if (rd) new_d = 1'b0;
    else         new_d = new_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SLOT_IDLE;
      smp_q <= '0;
      new_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      new_q <= new_d;
      if (cap) smp_q <= smp_d;
    end
  end

  assign sample = smp_q;
  assign fresh  = new_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cap) |=> !fresh); // R8
  AST_CAP_OVERWRITES: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> fresh && (sample == $past(din))); // R9
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sample)); // R2
  AST_OFF_DROPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cap); // R12

endmodule

// File: rtl/pc_sampler.sv
module pc_sampler
  import pcs_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ASID_W   = 8,
  parameter int DA_W     = 32,
  parameter int RATE_W   = 3,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pc_en,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_miss_only,
  input  logic              cfg_drop_asid,
  input  logic              cfg_da_en,
  input  logic              cfg_da_qual,
  input  logic              ret_vld,
  input  logic [PC_W-1:0]   ret_pc,
  input  logic [ASID_W-1:0] ret_asid,
  input  logic              ret_miss,
  input  logic              ls_vld,
  input  logic [DA_W-1:0]   ls_addr,
  input  logic              ls_bp0_hit,
  input  logic              pc_rd,
  input  logic              da_rd,
  output logic [PC_W-1:0]   pc_smp_pc,
  output logic [ASID_W-1:0] pc_smp_asid,
  output logic              pc_smp_new,
  output logic [DA_W-1:0]   da_smp_addr,
  output logic              da_smp_new
);

  localparam int PCS_W = PC_W + ASID_W;

  logic             tick, run;
  logic             pc_evt, pc_cap;
  logic [PCS_W-1:0] pc_din, pc_smp;

  assign run = cfg_pc_en | (HAS_DATA & cfg_da_en);

  pcs_interval_timer #(.RATE_W(RATE_W), .BASE_SHIFT(PCS_BASE_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(cfg_rate), .tick(tick)
  );

  always_comb begin
    pc_evt = ret_vld && (!cfg_miss_only || ret_miss);
    pc_din = {(cfg_drop_asid ? {ASID_W{1'b0}} : ret_asid), ret_pc};
  end

  pcs_capture_slot #(.W(PCS_W)) u_pc_slot (
    .clk(clk), .rst_n(rst_n), .en(cfg_pc_en), .tick(tick), .evt(pc_evt),
    .rd(pc_rd), .din(pc_din), .sample(pc_smp), .fresh(pc_smp_new), .cap(pc_cap)
  );

  assign pc_smp_pc   = pc_smp[PC_W-1:0];
  assign pc_smp_asid = pc_smp[PCS_W-1:PC_W];

  AST_MISS_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    pc_cap |-> (!cfg_miss_only || ret_miss)); // R3
  AST_ASID_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_cap && cfg_drop_asid) |=> (pc_smp_asid == '0)); // R4

  generate
    if (HAS_DATA) begin : g_data
      logic da_evt, da_cap;
      assign da_evt = ls_vld && (!cfg_da_qual || ls_bp0_hit);

      pcs_capture_slot #(.W(DA_W)) u_da_slot (
        .clk(clk), .rst_n(rst_n), .en(cfg_da_en), .tick(tick), .evt(da_evt),
        .rd(da_rd), .din(ls_addr), .sample(da_smp_addr), .fresh(da_smp_new),
        .cap(da_cap)
      );

      AST_DA_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        da_cap |-> (!cfg_da_qual || ls_bp0_hit)); // R6
      AST_DA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        da_cap |-> cfg_da_en); // R5
    end else begin : g_no_data
      assign da_smp_addr = '0;
      assign da_smp_new  = 1'b0;
    end
  endgenerate

endmodule

// File: tb/test_pc_sampler.sv
module test_pc_sampler;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_pc_en, cfg_miss_only, cfg_drop_asid, cfg_da_en, cfg_da_qual;
  logic [2:0]  cfg_rate;
  logic        ret_vld, ret_miss, ls_vld, ls_bp0_hit, pc_rd, da_rd;
  logic [31:0] ret_pc, ls_addr;
  logic [7:0]  ret_asid;
  logic [31:0] pc_smp_pc, da_smp_addr;
  logic [7:0]  pc_smp_asid;
  logic        pc_smp_new, da_smp_new;

  always #5 clk = ~clk;

  pc_sampler i_pc_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_pc_en(cfg_pc_en), .cfg_rate(cfg_rate),
    .cfg_miss_only(cfg_miss_only), .cfg_drop_asid(cfg_drop_asid),
    .cfg_da_en(cfg_da_en), .cfg_da_qual(cfg_da_qual), .ret_vld(ret_vld),
    .ret_pc(ret_pc), .ret_asid(ret_asid), .ret_miss(ret_miss), .ls_vld(ls_vld),
    .ls_addr(ls_addr), .ls_bp0_hit(ls_bp0_hit), .pc_rd(pc_rd), .da_rd(da_rd),
    .pc_smp_pc(pc_smp_pc), .pc_smp_asid(pc_smp_asid), .pc_smp_new(pc_smp_new),
    .da_smp_addr(da_smp_addr), .da_smp_new(da_smp_new)
  );

  int checks = 0;
  int errors = 0;
  int cyc_no = 0;
  int pc_seen = 0;
  bit auto_read = 1'b1;

  // expected-item queues (scoreboard)
  logic [39:0] exp_pc_q[$];
  logic [31:0] exp_da_q[$];

  // requirement-level reference state
  int m_cnt = 0;
  bit m_pc_arm = 1'b0;
  bit m_da_arm = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: predict the edge outcome from the current inputs, then advance.
  task automatic cyc();
    bit run, tick, pfire, dfire;
    int lim;
    lim   = 1 << (5 + cfg_rate);
    run   = cfg_pc_en || cfg_da_en;
    tick  = run && (m_cnt >= lim - 1);
    pfire = m_pc_arm && cfg_pc_en && ret_vld && (!cfg_miss_only || ret_miss);
    dfire = m_da_arm && cfg_da_en && ls_vld && (!cfg_da_qual || ls_bp0_hit);
    if (pfire) exp_pc_q.push_back({(cfg_drop_asid ? 8'h00 : ret_asid), ret_pc});
    if (dfire) exp_da_q.push_back(ls_addr);
    m_cnt    = (!run || tick) ? 0 : m_cnt + 1;
    m_pc_arm = !cfg_pc_en ? 1'b0 : tick ? 1'b1 : pfire ? 1'b0 : m_pc_arm;
    m_da_arm = !cfg_da_en ? 1'b0 : tick ? 1'b1 : dfire ? 1'b0 : m_da_arm;
    @(posedge clk);
    #2;
    cyc_no++;
  endtask

  task automatic traffic(input int n, input int ret_every, input int miss_every,
                         input int ls_every, input int bp_every);
    for (int i = 0; i < n; i++) begin
      ret_vld    = (i % ret_every) == 0;
      ret_pc     = {cyc_no[29:0], 2'b00};
      ret_asid   = cyc_no[7:0] ^ 8'h5A;
      ret_miss   = (i % miss_every) == 0;
      ls_vld     = (i % ls_every) == 0;
      ls_addr    = ~cyc_no;
      ls_bp0_hit = (i % bp_every) == 0;
      cyc();
    end
    ret_vld = 1'b0;
    ls_vld  = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 4; i++) cyc();
    chk(exp_pc_q.size() == 0, req, "pc samples not produced", 64'(exp_pc_q.size()), 0);
    chk(exp_da_q.size() == 0, req, "da samples not produced", 64'(exp_da_q.size()), 0);
    exp_pc_q.delete();
    exp_da_q.delete();
  endtask

  task automatic timer_restart();
    cfg_pc_en = 1'b0;
    cfg_da_en = 1'b0;
    cyc();
  endtask

  // Monitor: compare every fresh sample with the head of its queue.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && auto_read) begin
      if (pc_smp_new) begin
        pc_seen++;
        if (exp_pc_q.size() == 0)
          chk(1'b0, "R1", "unexpected pc sample", {pc_smp_asid, pc_smp_pc}, 0);
        else begin
          logic [39:0] e;
          e = exp_pc_q.pop_front();
          chk({pc_smp_asid, pc_smp_pc} == e, "R1", "pc sample", {pc_smp_asid, pc_smp_pc}, e);
        end
      end
      if (da_smp_new) begin
        if (exp_da_q.size() == 0)
          chk(1'b0, "R5", "unexpected da sample", da_smp_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_da_q.pop_front();
          chk(da_smp_addr == e, "R5", "da sample", da_smp_addr, e);
        end
      end
      pc_rd = pc_smp_new;
      da_rd = da_smp_new;
    end
  end

  initial begin
    #(150000 * 10);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0;
    cfg_pc_en = 1'b0; cfg_rate = 3'd0; cfg_miss_only = 1'b0; cfg_drop_asid = 1'b0;
    cfg_da_en = 1'b0; cfg_da_qual = 1'b0;
    ret_vld = 1'b0; ret_pc = '0; ret_asid = '0; ret_miss = 1'b0;
    ls_vld = 1'b0; ls_addr = '0; ls_bp0_hit = 1'b0; pc_rd = 1'b0; da_rd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(pc_smp_new == 1'b0, "R10", "pc new after reset", 64'(pc_smp_new), 0);
    chk(da_smp_new == 1'b0, "R10", "da new after reset", 64'(da_smp_new), 0);
    chk({pc_smp_asid, pc_smp_pc} == '0, "R10", "pc sample after reset", {pc_smp_asid, pc_smp_pc}, 0);
    chk(da_smp_addr == '0, "R10", "da sample after reset", da_smp_addr, 0);
    rst_n = 1'b1;
    cyc();

    // R1: rate 0, retire every cycle -> six captures in 200 cycles
    timer_restart();
    cfg_pc_en = 1'b1;
    base = pc_seen;
    traffic(200, 1, 1, 1, 1);
    drain("R1");
    chk(pc_seen - base == 6, "R1", "sample count at rate 0", 64'(pc_seen - base), 6);

    // R3: miss-only filter
    cfg_miss_only = 1'b1; cfg_rate = 3'd1;
    traffic(400, 1, 7, 1, 1);
    drain("R3");
    cfg_miss_only = 1'b0;

    // R4: ASID dropped
    cfg_drop_asid = 1'b1; cfg_rate = 3'd0;
    traffic(150, 1, 1, 1, 1);
    drain("R4");
    cfg_drop_asid = 1'b0;

    // R5: data slot together with PC slot, then alone
    cfg_da_en = 1'b1;
    traffic(200, 3, 1, 2, 1);
    cfg_pc_en = 1'b0;
    traffic(200, 1, 1, 5, 1);
    drain("R5");

    // R6: breakpoint-0 qualifier
    cfg_da_qual = 1'b1;
    traffic(300, 1, 1, 1, 11);
    drain("R6");
    cfg_da_qual = 1'b0; cfg_da_en = 1'b0;

    // R7: sparse events, arm persists
    cfg_pc_en = 1'b1;
    base = pc_seen;
    traffic(600, 97, 1, 1, 1);
    drain("R7");
    chk(pc_seen - base >= 5, "R7", "late events still sampled", 64'(pc_seen - base), 5);

    // R12: disable mid-interval drops the arm
    traffic(40, 1000, 1, 1, 1);
    cfg_pc_en = 1'b0;
    traffic(3, 1, 1, 1, 1);
    cfg_pc_en = 1'b1;
    traffic(80, 1, 1, 1, 1);
    drain("R12");

    // R2: everything disabled
    cfg_pc_en = 1'b0; cfg_da_en = 1'b0;
    base = pc_seen;
    traffic(300, 1, 1, 1, 1);
    drain("R2");
    chk(pc_seen == base, "R2", "samples while disabled", 64'(pc_seen - base), 0);
    chk(pc_smp_new == 1'b0, "R2", "pc new while disabled", 64'(pc_smp_new), 0);

    // R11: longest interval
    timer_restart();
    cfg_pc_en = 1'b1; cfg_rate = 3'd7;
    base = pc_seen;
    traffic(9000, 1, 1, 1, 1);
    drain("R11");
    chk(pc_seen - base == 2, "R11", "sample count at rate 7", 64'(pc_seen - base), 2);

    // R9 / R8: unread overwrite, then read clears
    timer_restart();
    auto_read = 1'b0;
    pc_rd = 1'b0; da_rd = 1'b0;
    cfg_pc_en = 1'b1; cfg_rate = 3'd0;
    traffic(70, 1, 1, 1, 1);
    cfg_pc_en = 1'b0;
    cyc(); cyc();
    chk(exp_pc_q.size() == 2, "R9", "captures in window", 64'(exp_pc_q.size()), 2);
    chk(pc_smp_new == 1'b1, "R9", "flag set while unread", 64'(pc_smp_new), 1);
    chk({pc_smp_asid, pc_smp_pc} == exp_pc_q[$], "R9", "newest sample kept",
        {pc_smp_asid, pc_smp_pc}, exp_pc_q[$]);
    pc_rd = 1'b1;
    cyc();
    pc_rd = 1'b0;
    chk(pc_smp_new == 1'b0, "R8", "flag after read", 64'(pc_smp_new), 0);
    exp_pc_q.delete();
    cyc();
    auto_read = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule